// File: doc/BRIEF.md
# Segmented Address Byte/Word Access Unit

This block takes a logical address given as a 16-bit segment and a 16-bit offset and turns it into a 20-bit physical address. The physical address is the segment moved up by four bit positions plus the offset. The block then performs the access over a memory port that carries one byte at a time. A byte request produces one byte transfer. A word request produces two transfers, and the least significant byte always goes first.

A client presents a request when `busy` is low. The request carries a segment, an offset, a write flag, a word flag and 16 bits of write data. Each transfer on the memory side holds its address, direction and write byte stable until the memory answers with a ready pulse.

When the final byte has been acknowledged, `done` pulses for one cycle. On a read, the assembled result is presented on `rdata` at that moment. A byte read returns its value zero-extended to 16 bits.

Top module: `seg_access_unit`

## Requirements
- R1: For the first transfer of any request, `mem_addr` equals (segment × 16 + offset), which is a 20-bit value. For example, segment 2F84h with offset 0532h gives 2FD72h.
- R2: A physical sum above FFFFFh wraps modulo 2^20. For example, FFFF:FFFF gives 0FFEFh and FFFF:0010 gives 00000h.
- R3: A byte request makes exactly one transfer and a word request makes exactly two. The second transfer of a word uses offset+1, wrapped to 16 bits, with the same segment. `mem_we` equals the request's write flag on every transfer.
- R4: On a write, the first transfer carries write data bits 7:0 and the second carries bits 15:8. A byte write sends only bits 7:0.
- R5: On a read, the first byte received lands in `rdata[7:0]` and the second in `rdata[15:8]`. A byte read leaves `rdata[15:8]` at zero. `rdata` is valid while `done` is high.
- R6: `done` is high for exactly one cycle, in the cycle right after the edge where the last transfer had `mem_ready` high.
- R7: A request is taken only while `busy` is low. `busy` rises in the cycle after acceptance and stays high through the `done` cycle. While `busy` is high, `req_valid` and the request fields have no effect.
- R8: While `mem_req` is high and `mem_ready` is low, the next cycle keeps `mem_req` high and keeps `mem_addr` and `mem_wdata` unchanged.
- R9: After reset, `busy`, `done` and `mem_req` are low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_seg | input | 16 | Segment part of the logical address |
| req_off | input | 16 | Offset part of the logical address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Assembled read data |
| mem_req | output | 1 | Byte transfer pending |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte from memory |
| mem_ready | input | 1 | Memory completes the pending transfer |

## Verification
Acceptance happens on the edge where `req_valid` is seen with `busy` low. `mem_req`, the first address and `busy` appear in the cycle after that edge. Each further byte transfer follows the edge at which `mem_ready` was high, and `done` and the final `rdata` come one cycle after the last such edge. The bench keeps a behavioural model built on queues of expected transfers. It updates that model at the same edges and compares it with every output in the middle of every cycle, so every output is checked in the exact cycle it is due. The bench also varies the number of memory wait cycles to exercise the stall hold.

// File: rtl/seg_acc_pkg.sv
package seg_acc_pkg;
    parameter int unsigned SEG_W     = 16;
    parameter int unsigned OFF_W     = 16;
    parameter int unsigned SEG_SHIFT = 4;
    parameter int unsigned BYTE_W    = 8;
    localparam int unsigned PA_W     = SEG_W + SEG_SHIFT;
    localparam int unsigned WORD_W   = 2 * BYTE_W;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LO   = 2'd1,
        PH_HI   = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e             ph;
        logic [SEG_W-1:0]   seg;
        logic [OFF_W-1:0]   off;
        logic               we;
        logic               word;
        logic [WORD_W-1:0]  wdata;
        logic [WORD_W-1:0]  rdata;
    } acc_state_t;
endpackage

// File: rtl/seg_xlate.sv
module seg_xlate #(
    parameter int unsigned SEG_W     = 16,
    parameter int unsigned OFF_W     = 16,
    parameter int unsigned SEG_SHIFT = 4,
    localparam int unsigned PA_W     = SEG_W + SEG_SHIFT
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  pa
);
    logic [PA_W-1:0] base_w;
    logic [PA_W-1:0] off_w;

    // Segment base is the segment moved up by SEG_SHIFT bits; the sum wraps.
    assign base_w = {seg, {SEG_SHIFT{1'b0}}};
    assign off_w  = PA_W'(off);
    assign pa     = base_w + off_w;
endmodule

// File: rtl/seg_lane_mux.sv
module seg_lane_mux #(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned WORD_W = 2 * BYTE_W
) (
    input  logic              hi_lane,
    input  logic [WORD_W-1:0] wword,
    output logic [BYTE_W-1:0] wbyte,
    input  logic [WORD_W-1:0] rword_in,
    input  logic [BYTE_W-1:0] rbyte,
    output logic [WORD_W-1:0] rword_out
);
    // Write side: pick the byte lane for the current transfer.
    assign wbyte = hi_lane ? wword[WORD_W-1:BYTE_W] : wword[BYTE_W-1:0];

    // Read side: drop the returned byte into its lane, keep the other lane.
    always_comb begin
        rword_out = rword_in;
        if (hi_lane) rword_out[WORD_W-1:BYTE_W] = rbyte;
        else         rword_out[BYTE_W-1:0]      = rbyte;
    end
endmodule

// File: rtl/seg_access_unit.sv
module seg_access_unit
    import seg_acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    acc_state_t        st_d, st_q;
    logic              hi_lane;
    logic [OFF_W-1:0]  cur_off;
    logic [WORD_W-1:0] merged;

    assign hi_lane = (st_q.ph == PH_HI);
    // Second byte of a word: offset + 1 wrapping inside the segment.
    assign cur_off = hi_lane ? (st_q.off + OFF_W'(1)) : st_q.off;

    seg_xlate #(
        .SEG_W     (SEG_W),
        .OFF_W     (OFF_W),
        .SEG_SHIFT (SEG_SHIFT)
    ) u_xlate (
        .seg (st_q.seg),
        .off (cur_off),
        .pa  (mem_addr)
    );

    seg_lane_mux #(
        .BYTE_W (BYTE_W)
    ) u_lane (
        .hi_lane   (hi_lane),
        .wword     (st_q.wdata),
        .wbyte     (mem_wdata),
        .rword_in  (st_q.rdata),
        .rbyte     (mem_rdata),
        .rword_out (merged)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.ph    = PH_LO;
                    st_d.seg   = req_seg;
                    st_d.off   = req_off;
                    st_d.we    = req_write;
                    st_d.word  = req_word;
                    st_d.wdata = req_wdata;
                    st_d.rdata = '0;
                end
            end
            PH_LO: begin
                if (mem_ready) begin
                    if (!st_q.we) st_d.rdata = merged;
                    st_d.ph = st_q.word ? PH_HI : PH_DONE;
                end
            end
            PH_HI: begin
                if (mem_ready) begin
                    if (!st_q.we) st_d.rdata = merged;
                    st_d.ph = PH_DONE;
                end
            end
            PH_DONE: st_d.ph = PH_IDLE;
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = (st_q.ph != PH_IDLE);
    assign done    = (st_q.ph == PH_DONE);
    assign mem_req = (st_q.ph == PH_LO) || (st_q.ph == PH_HI);
    assign mem_we  = st_q.we;
    assign rdata   = st_q.rdata;

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_req && mem_ready));

    // R7
    req_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

    // R5
    byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !st_q.word && !st_q.we) |-> (rdata[WORD_W-1:BYTE_W] == '0));
endmodule

// File: tb/tb_seg_access_unit.sv
module tb_seg_access_unit;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_seg = '0;
    logic [15:0] req_off = '0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        busy, done;
    logic [15:0] rdata;
    logic        mem_req, mem_we;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ready = 1'b0;

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    int wait_cfg = 0;

    // behavioural model state
    logic [19:0] qa[$];
    logic [7:0]  qd[$];
    bit          m_busy = 0, m_done = 0, m_we = 0, done_n;
    logic [15:0] m_rdata = '0;
    int          m_idx = 0, wcnt = 0;

    seg_access_unit dut (
        .clk, .rst_n, .req_valid, .req_seg, .req_off, .req_write, .req_word,
        .req_wdata, .busy, .done, .rdata, .mem_req, .mem_we, .mem_addr,
        .mem_wdata, .mem_rdata, .mem_ready
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [19:0] phys(logic [15:0] s, logic [15:0] o);
        int p;
        p = (int'(s) << 4) + int'(o);
        return p[19:0];
    endfunction

    function automatic logic [7:0] memfn(logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h5A;
    endfunction

    task automatic summary();
        $display("test done: total=%0d bad=%0d", checks, bad);
    endtask

    // Reference model and memory responder, mid-cycle
    always @(negedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 50000);
            summary();
            $finish;
        end
        if (!rst_n) begin
            qa.delete(); qd.delete();
            m_busy = 0; m_done = 0; m_rdata = '0; mem_ready = 1'b0;
        end else begin
            chk(busy === m_busy, "R7", "busy", busy, m_busy);
            chk(done === m_done, "R6", "done", done, m_done);
            chk(mem_req === (qa.size() > 0), "R3", "mem_req", mem_req, qa.size() > 0);
            if (qa.size() > 0) begin
                chk(mem_addr === qa[0], "R1", "mem_addr", mem_addr, qa[0]);
                chk(mem_we === m_we, "R3", "mem_we", mem_we, m_we);
                if (m_we) chk(mem_wdata === qd[0], "R4", "mem_wdata", mem_wdata, qd[0]);
            end
            if (m_done && !m_we) chk(rdata === m_rdata, "R5", "rdata", rdata, m_rdata);

            done_n = 0;
            mem_ready = 1'b0;
            if (qa.size() > 0) begin
                if (wcnt == 0) begin
                    mem_ready = 1'b1;
                    mem_rdata = memfn(qa[0]);
                    if (m_idx == 0) m_rdata[7:0] = mem_rdata;
                    else            m_rdata[15:8] = mem_rdata;
                    m_idx++;
                    void'(qa.pop_front());
                    void'(qd.pop_front());
                    wcnt = wait_cfg;
                    if (qa.size() == 0) done_n = 1;
                end else begin
                    wcnt--;
                end
            end
            if (!m_busy && req_valid) begin
                qa.push_back(phys(req_seg, req_off));
                qd.push_back(req_wdata[7:0]);
                if (req_word) begin
                    qa.push_back(phys(req_seg, req_off + 16'd1));
                    qd.push_back(req_wdata[15:8]);
                end
                m_we = req_write;
                m_rdata = '0;
                m_idx = 0;
                wcnt = wait_cfg;
            end
            m_busy = (qa.size() > 0) || done_n;
            m_done = done_n;
        end
    end

    task automatic do_req(logic [15:0] s, logic [15:0] o, bit we, bit word,
                          logic [15:0] wd, int wt, logic [19:0] exp_pa,
                          string rq, bit junk);
        @(posedge clk); #1;
        while (busy) begin @(posedge clk); #1; end
        wait_cfg  = wt;
        req_valid = 1'b1; req_seg = s; req_off = o;
        req_write = we; req_word = word; req_wdata = wd;
        @(posedge clk); #1;
        chk(mem_req && busy, "R7", "accepted", {busy, mem_req}, 2'b11);
        chk(mem_addr === exp_pa, rq, "first address", mem_addr, exp_pa);
        if (junk) begin
            // R7: changed fields while busy must not alter the transfer
            req_seg = ~s; req_off = o ^ 16'h00F0; req_write = ~we; req_wdata = ~wd;
        end else begin
            req_valid = 1'b0;
        end
        while (!done) begin @(posedge clk); #1; end
        req_valid = 1'b0;
        if (!we && !word) chk(rdata[15:8] == 8'h00, "R5", "zero extend", rdata[15:8], 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        chk(!busy && !done && !mem_req && rdata == 16'h0, "R9", "reset outputs",
            {busy, done, mem_req, rdata}, 0);
        rst_n = 1'b1;

        do_req(16'h2F84, 16'h0532, 0, 0, 16'h0000, 0, 20'h2FD72, "R1", 0);
        do_req(16'h1234, 16'h0010, 0, 1, 16'h0000, 2, 20'h12350, "R1", 0);
        // R3 word crossing offset FFFF wraps within the segment
        do_req(16'h0100, 16'hFFFF, 1, 1, 16'hA55A, 1, 20'h10FFF, "R3", 0);
        do_req(16'hFFFF, 16'hFFFF, 0, 0, 16'h0000, 0, 20'h0FFEF, "R2", 0);
        do_req(16'hFFFF, 16'h0010, 0, 1, 16'h0000, 1, 20'h00000, "R2", 0);
        // R4 byte write sends only the low byte
        do_req(16'h0000, 16'h0000, 1, 0, 16'h12EF, 0, 20'h00000, "R4", 0);
        // R8 long stalls
        do_req(16'h4000, 16'h8001, 1, 1, 16'hBEEF, 4, 20'h48001, "R8", 0);
        // R7 request held with altered fields while busy
        do_req(16'h0ABC, 16'h1111, 0, 1, 16'h0000, 3, 20'h0BCD1, "R7", 1);
        do_req(16'h7777, 16'h0003, 1, 1, 16'h0102, 0, 20'h77773, "R6", 1);

        repeat (4) @(posedge clk);
        #1;
        chk(!busy && !mem_req, "R7", "idle at end", {busy, mem_req}, 0);
        summary();
        $finish;
    end
endmodule